// File: doc/BRIEF.md
# Queued Step Pulse Timer

This block produces one precisely timed, active-low step pulse per requested period for a stepper motor driver. A period is a 32-bit count of clock cycles measured from one step's falling edge to the next. It is timed against a free-running counter that is never cleared. The upper half of the period is spent as whole counter wraps and the lower half as a final compare. Each new compare point is added to the previous compare value rather than to the time of loading, so the step rate stays exact however late the next period arrives.

Two outputs idle high. The step is the interval in which output A is low while output B is still high. At the final compare A drops, which is the driver's clocking edge. A fixed pulse width later B drops, which ends the active interval. A then rises, and B rises one cycle after it. A single queue slot holds the next period, so consecutive steps follow each other with no gap. A next-period strobe tells the supplier when to provide another period. Loads that are too short, or that arrive while the slot is full, are refused with an error pulse.

A final residue that is too short or too long is re-split into a lead-in compare plus a remainder. This keeps every final compare and pulse within a comfortable distance of a counter wrap without changing the total period.

Top module: `step_pulse_sched`

## Requirements
- R1: After reset both step outputs are high, `busy` is low and `next_req` is low.
- R2: A load whose period is below MIN_SETUP raises `ld_err` (and not `ld_ack`) in the same cycle. Busy state, queue and outputs are unchanged.
- R3: A load while `busy` is high and the queue slot is full raises `ld_err` in the same cycle. The running period and the queued period are unchanged.
- R4: A load accepted while idle starts at once. Output A falls exactly P clock edges after the accepting edge, and `next_req` pulses high in the cycle after acceptance.
- R5: A load accepted while busy is queued. Its falling edge of A lands exactly P cycles after the previous falling edge of A.
- R6: Output B falls exactly PULSE_TIME cycles after output A falls.
- R7: Output A rises one cycle after B falls, and B rises one cycle after that. B never rises while A is low.
- R8: When a pulse ends with the queue empty, the block goes idle with both outputs high and `busy` low.
- R9: When a pulse ends with a period queued, or with a load arriving in that same cycle, that period starts at once, `busy` stays high and `next_req` pulses.
- R10: The bits of P above the counter width are spent as whole counter wraps before the final compare, and the total stays exactly P.
- R11: If the low residue of P (bits below the counter width) is below MIN_SETUP, one wrap is borrowed. The first compare lies MID_SET−MIN_SETUP ahead, and the total stays exactly P.
- R12: If the low residue of P exceeds MAX_SETUP, the first compare lies MAX_SETUP−MID_SET ahead, and the total stays exactly P.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_req | input | 1 | Request to load a step period |
| ld_period | input | PER_W | Step period in clock cycles |
| ld_ack | output | 1 | Load accepted (same cycle as request) |
| ld_err | output | 1 | Load refused (same cycle as request) |
| busy | output | 1 | A step period is being timed |
| next_req | output | 1 | One-cycle strobe asking for the next period |
| step_a_n | output | 1 | Output A; falling edge starts the step |
| step_b_n | output | 1 | Output B; falling edge ends the active interval |

## Verification
The main function is tried with periods that hit each split path: a plain residue with no wraps, a residue plus one wrap, a residue above the upper setup limit, residues below the lower limit with and without a wrap, a residue of zero, several wraps plus a long residue, and the minimum legal period. Each of these tells apart a different path in the split, because a wrong lead-in or remainder moves the falling edge. Edge timestamps are compared against cumulative sums of the requested periods. This separates anchoring to the previous compare from anchoring to the load time. It also shows whether an idle start counts from the accepting edge. Rejected loads (a short period, a full queue) are followed by the exact edge times of the steps already running, which shows that the refusal left the running period and the queue untouched.

// File: rtl/sps_pkg.sv
package sps_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ROLL  = 2'd1,
        PH_FINAL = 2'd2,
        PH_PULSE = 2'd3
    } sps_phase_e;
endpackage

// File: rtl/sps_free_counter.sv
module sps_free_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] cnt
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/sps_period_split.sv
module sps_period_split
    import sps_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int PER_W      = 32,
    parameter int MIN_SETUP  = 1000,
    parameter int MID_SET    = 20000,
    parameter int MAX_SETUP  = 60000
) (
    input  logic [PER_W-1:0] period,
    input  logic [CNT_W-1:0] base,
    output sps_phase_e       phase,
    output logic [CNT_W-1:0] cmp,
    output logic [PER_W:0]   rem
);
    localparam int RW          = PER_W + 1;
    localparam int BORROW_LEAD = MID_SET - MIN_SETUP;
    localparam int TRIM_LEAD   = MAX_SETUP - MID_SET;
    localparam logic [RW-1:0] WRAP = RW'(1) << CNT_W;

    logic [CNT_W-1:0] lo;
    logic             hi_nz;

    assign lo    = period[CNT_W-1:0];
    assign hi_nz = |period[PER_W-1:CNT_W];

    always_comb begin
        rem   = {1'b0, period};
        phase = PH_ROLL;
        cmp   = base;
        if (lo < CNT_W'(MIN_SETUP)) begin
            // short residue: borrow one wrap, lead in by the borrow distance
            cmp = base + CNT_W'(BORROW_LEAD);
            rem = {1'b0, period} + WRAP - RW'(BORROW_LEAD);
        end else if (lo > CNT_W'(MAX_SETUP)) begin
            // long residue: lead in so the final compare sits well clear of a wrap
            cmp = base + CNT_W'(TRIM_LEAD);
            rem = {1'b0, period} + WRAP - RW'(TRIM_LEAD);
        end else if (!hi_nz) begin
            phase = PH_FINAL;
            cmp   = base + lo;
        end
    end
endmodule

// File: rtl/step_pulse_sched.sv
module step_pulse_sched
    import sps_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int PER_W      = 32,
    parameter int PULSE_TIME = 100,
    parameter int MIN_SETUP  = 1000,
    parameter int MID_SET    = 20000,
    parameter int MAX_SETUP  = 60000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_req,
    input  logic [PER_W-1:0] ld_period,
    output logic             ld_ack,
    output logic             ld_err,
    output logic             busy,
    output logic             next_req,
    output logic             step_a_n,
    output logic             step_b_n
);
    localparam int RW = PER_W + 1;
    localparam logic [RW-1:0] WRAP = RW'(1) << CNT_W;

    typedef struct packed {
        sps_phase_e       phase;
        logic [CNT_W-1:0] cmp;    // next compare point
        logic [CNT_W-1:0] acmp;   // compare point of the last falling A edge
        logic [RW-1:0]    rem;    // remaining wraps and residue
        logic             q_vld;
        logic [PER_W-1:0] q_per;
        logic             a_n;
        logic             b_n;
        logic [1:0]       rest;   // 1: raise A next, 2: raise B next
        logic             nreq;
    } state_t;

    state_t st_d, st_q;

    logic [CNT_W-1:0] cnt;
    logic [PER_W-1:0] cont_per;
    logic             hit;
    logic             reject;
    logic [RW-1:0]    rem_m;
    logic             q_full;

    sps_phase_e       s_idle_phase, s_cont_phase;
    logic [CNT_W-1:0] s_idle_cmp,   s_cont_cmp;
    logic [RW-1:0]    s_idle_rem,   s_cont_rem;

    sps_free_counter #(.W(CNT_W)) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .cnt  (cnt)
    );

    assign cont_per = st_q.q_vld ? st_q.q_per : ld_period;

    // start from idle: anchored to the current counter value
    sps_period_split #(
        .CNT_W(CNT_W), .PER_W(PER_W), .MIN_SETUP(MIN_SETUP),
        .MID_SET(MID_SET), .MAX_SETUP(MAX_SETUP)
    ) u_split_idle (
        .period(ld_period), .base(cnt),
        .phase(s_idle_phase), .cmp(s_idle_cmp), .rem(s_idle_rem)
    );

    // back-to-back step: anchored to the previous A compare point
    sps_period_split #(
        .CNT_W(CNT_W), .PER_W(PER_W), .MIN_SETUP(MIN_SETUP),
        .MID_SET(MID_SET), .MAX_SETUP(MAX_SETUP)
    ) u_split_cont (
        .period(cont_per), .base(st_q.acmp),
        .phase(s_cont_phase), .cmp(s_cont_cmp), .rem(s_cont_rem)
    );

    always_comb begin
        hit    = (cnt == st_q.cmp);
        busy   = (st_q.phase != PH_IDLE);
        reject = (ld_period < PER_W'(MIN_SETUP)) || (busy && st_q.q_vld);
        ld_err = ld_req && reject;
        ld_ack = ld_req && !reject;
        rem_m  = st_q.rem - WRAP;

        st_d      = st_q;
        st_d.nreq = 1'b0;

        // ordered release after the active interval
        if (st_q.rest == 2'd1) begin
            st_d.a_n  = 1'b1;
            st_d.rest = 2'd2;
        end else if (st_q.rest == 2'd2) begin
            st_d.b_n  = 1'b1;
            st_d.rest = 2'd0;
        end

        if (ld_ack && busy) begin
            st_d.q_vld = 1'b1;
            st_d.q_per = ld_period;
        end

        unique case (st_q.phase)
            PH_IDLE: begin
                if (ld_ack) begin
                    st_d.phase = s_idle_phase;
                    st_d.cmp   = s_idle_cmp;
                    st_d.rem   = s_idle_rem;
                    st_d.nreq  = 1'b1;
                end
            end
            PH_ROLL: begin
                if (hit) begin
                    st_d.rem = rem_m;
                    if (rem_m[RW-1:CNT_W] == '0) begin
                        st_d.cmp   = st_q.cmp + rem_m[CNT_W-1:0];
                        st_d.phase = PH_FINAL;
                    end
                end
            end
            PH_FINAL: begin
                if (hit) begin
                    st_d.a_n   = 1'b0;
                    st_d.acmp  = st_q.cmp;
                    st_d.cmp   = st_q.cmp + CNT_W'(PULSE_TIME);
                    st_d.phase = PH_PULSE;
                end
            end
            PH_PULSE: begin
                if (hit) begin
                    st_d.b_n  = 1'b0;
                    st_d.rest = 2'd1;
                    if (st_q.q_vld || ld_ack) begin
                        st_d.phase = s_cont_phase;
                        st_d.cmp   = s_cont_cmp;
                        st_d.rem   = s_cont_rem;
                        st_d.q_vld = 1'b0;
                        st_d.nreq  = 1'b1;
                    end else begin
                        st_d.phase = PH_IDLE;
                    end
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.a_n <= 1'b1;
            st_q.b_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign next_req = st_q.nreq;
    assign step_a_n = st_q.a_n;
    assign step_b_n = st_q.b_n;
    assign q_full   = st_q.q_vld;
endmodule

// File: rtl/step_pulse_sched_chk.sv
module step_pulse_sched_chk #(
    parameter int PER_W     = 32,
    parameter int MIN_SETUP = 1000
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ld_req,
    input logic [PER_W-1:0] ld_period,
    input logic             ld_ack,
    input logic             ld_err,
    input logic             busy,
    input logic             next_req,
    input logic             step_a_n,
    input logic             step_b_n,
    input logic             q_full
);
    AST_ACK_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ld_ack, ld_err})); // R2

    AST_SHORT_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_req && ld_period < PER_W'(MIN_SETUP)) |-> ld_err); // R2

    AST_FULL_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_req && busy && q_full) |-> (ld_err && !ld_ack)); // R3

    AST_IDLE_START_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_ack && !busy) |=> (next_req && busy)); // R4

    AST_B_FALL_WITH_A_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(step_b_n) |-> !step_a_n); // R6

    AST_A_RISES_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(step_a_n) |-> !step_b_n); // R7

    AST_B_RISES_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(step_b_n) |-> $past(step_a_n)); // R7

    AST_IDLE_QUEUE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !q_full); // R8
endmodule

bind step_pulse_sched step_pulse_sched_chk #(
    .PER_W    (PER_W),
    .MIN_SETUP(MIN_SETUP)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_req   (ld_req),
    .ld_period(ld_period),
    .ld_ack   (ld_ack),
    .ld_err   (ld_err),
    .busy     (busy),
    .next_req (next_req),
    .step_a_n (step_a_n),
    .step_b_n (step_b_n),
    .q_full   (q_full)
);

// File: tb/step_pulse_sched_bench.sv
`timescale 1ns/1ps
module step_pulse_sched_bench;
    localparam int CW = 8;
    localparam int PW = 32;
    localparam int PT = 4;
    localparam int MN = 16;
    localparam int MD = 40;
    localparam int MX = 200;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_req = 1'b0;
    logic [PW-1:0] ld_period = '0;
    logic          ld_ack, ld_err, busy, next_req, step_a_n, step_b_n;

    step_pulse_sched #(
        .CNT_W(CW), .PER_W(PW), .PULSE_TIME(PT),
        .MIN_SETUP(MN), .MID_SET(MD), .MAX_SETUP(MX)
    ) u_step_pulse_sched (
        .clk(clk), .rst_n(rst_n), .ld_req(ld_req), .ld_period(ld_period),
        .ld_ack(ld_ack), .ld_err(ld_err), .busy(busy), .next_req(next_req),
        .step_a_n(step_a_n), .step_b_n(step_b_n)
    );

    always #2 clk = ~clk;

    longint cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        longint t;
        string  tag;
    } exp_t;
    exp_t   exp_q[$];
    int     n_chk = 0;
    int     n_bad = 0;
    longint last_exp = 0;
    bit     done = 1'b0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic load(input longint per, input bit want_ok, input string tag);
        bit was_busy;
        bit acc;
        @(negedge clk);
        ld_req    = 1'b1;
        ld_period = per[PW-1:0];
        #1;
        was_busy = busy;
        acc      = ld_ack;
        if (want_ok) chk(ld_ack && !ld_err, tag, {ld_ack, ld_err}, 2'b10);
        else         chk(ld_err && !ld_ack, tag, {ld_ack, ld_err}, 2'b01);
        if (acc) begin
            if (!was_busy) last_exp = cyc + 1 + per;
            else           last_exp = last_exp + per;
            exp_q.push_back('{last_exp, tag});
        end
        @(negedge clk);
        ld_req = 1'b0;
        if (acc && !was_busy) chk(next_req == 1'b1, "R4", next_req, 1);
        if (!want_ok)         chk(busy == was_busy, tag, busy, was_busy);
    endtask

    task automatic wait_nreq();
        while (!next_req) @(negedge clk);
        chk(busy == 1'b1, "R9", busy, 1);
    endtask

    task automatic drain();
        while (busy) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(step_a_n && step_b_n, "R8", {step_a_n, step_b_n}, 2'b11);
        chk(busy == 1'b0, "R8", busy, 0);
        chk(exp_q.size() == 0, "R8", exp_q.size(), 0);
    endtask

    // monitor: scoreboard of falling-edge times plus pulse shape
    initial begin
        bit     pa = 1'b1;
        bit     pb = 1'b1;
        longint afall = 0;
        longint bfall = 0;
        longint arise = 0;
        exp_t   e;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (pa && !step_a_n) begin
                    afall = cyc;
                    if (exp_q.size() == 0) chk(1'b0, "R5", cyc, -1);
                    else begin
                        e = exp_q.pop_front();
                        chk(cyc == e.t, e.tag, cyc, e.t);
                    end
                end
                if (pb && !step_b_n) begin
                    bfall = cyc;
                    chk(cyc - afall == PT, "R6", cyc - afall, PT);
                end
                if (!pa && step_a_n) begin
                    arise = cyc;
                    chk(cyc - bfall == 1, "R7", cyc - bfall, 1);
                end
                if (!pb && step_b_n) chk(cyc - arise == 1, "R7", cyc - arise, 1);
                pa = step_a_n;
                pb = step_b_n;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(step_a_n && step_b_n && !busy && !next_req, "R1",
            {step_a_n, step_b_n, busy, next_req}, 4'b1100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(step_a_n && step_b_n && !busy && !next_req, "R1",
            {step_a_n, step_b_n, busy, next_req}, 4'b1100);

        load(MN - 1, 1'b0, "R2");       // below minimum: refused
        load(100, 1'b1, "R4");          // idle start, residue only
        load(300, 1'b1, "R10");         // one wrap plus residue, queued
        load(50, 1'b0, "R3");           // queue already full
        wait_nreq();
        load(MN, 1'b1, "R5");           // minimum period, back to back
        wait_nreq();
        load(220, 1'b1, "R12");         // residue above upper limit
        wait_nreq();
        load(260, 1'b1, "R11");         // short residue with a wrap
        wait_nreq();
        load(1000, 1'b1, "R12");        // several wraps, long residue
        wait_nreq();
        load(256, 1'b1, "R11");         // zero residue
        wait_nreq();
        drain();

        load(MN, 1'b1, "R4");           // idle start at minimum period
        drain();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule